// File: doc/BRIEF.md
# Aligned Packet Command Node

This block sits on a byte-wide receive link and controls a small bank of LED outputs. After reset it only watches the incoming stream for alignment marker bytes (0x55). When it has seen a configured run of them back to back, it declares the link up. From then on it parses framed packets and acts on the ones addressed to it. Every byte it receives after the link is up is repeated on its output link one cycle later. Two or more nodes can therefore be chained, each with its own identifier. Until the link is up the output link stays silent.

A packet is the byte sequence start (0xFB), identifier, length, one or more command bytes, end (0xFD). Idle filler bytes (0x07) or any other bytes may sit between packets; they are ignored while the parser hunts for a start byte. Command effects are collected while the packet is parsed and are committed to the LED outputs only when a correct end byte closes the packet. A malformed packet raises a single-cycle error pulse and leaves the LEDs as they were.

Top module: `cmd_node`

## Requirements
- R1: `link_up` rises in the cycle after the ALIGN_RUN-th (default 5) consecutive accepted 0x55 byte and then stays high until reset.
- R2: Before `link_up` is set, any accepted byte other than 0x55 restarts the marker run from zero. Cycles with `in_vld` low neither advance nor break the run.
- R3: `out_vld` stays low for every byte accepted while `link_up` is low, including the marker that completes the run.
- R4: Every byte accepted while `link_up` is high appears on `out_byte` with `out_vld` high exactly one cycle later, in arrival order.
- R5: A packet 0xFB, ID, LEN, command bytes, 0xFD whose ID equals NODE_ID updates `led_o` in the cycle after its 0xFD byte. `led_o` changes at no other time.
- R6: A well-formed packet whose ID differs from NODE_ID leaves `led_o` unchanged and raises no error.
- R7: Command byte 0xN0 turns LED N on and 0xN1 turns it off, with N in the upper nibble (0x00 and 0x01 for LED0, 0x10 and 0x11 for LED1). Any other command value changes nothing.
- R8: A length byte of 0x00 raises `err_pulse` for exactly one cycle, in the cycle after that byte. The parser then hunts for a new start byte.
- R9: With a length above 1, the command bytes are applied in arrival order, so a later command to the same LED wins. The end byte is expected right after the last command.
- R10: If the byte after the last command is not 0xFD, `err_pulse` is high for one cycle and none of that packet's commands reach `led_o`.
- R11: A 0xFB byte in any position after the opening start byte raises `err_pulse` for one cycle and discards the packet. A following packet is parsed normally.
- R12: Reset clears `link_up`, `out_vld`, `err_pulse` and all bits of `led_o` (LEDs off).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Incoming byte is valid this cycle |
| in_byte | input | 8 | Incoming link byte |
| out_vld | output | 1 | Repeated byte is valid |
| out_byte | output | 8 | Repeated link byte |
| link_up | output | 1 | Alignment reached |
| led_o | output | LED_CNT | LED states, 1 = on |
| err_pulse | output | 1 | One-cycle malformed-packet flag |

## Verification
The hardest situation to reach from the ports is a discarded packet whose command bytes have already been staged: the LEDs must not move, although the parser has decoded valid commands. The stimulus sends addressed packets with a legal command followed by a wrong closing byte, and others with a stray start byte in the command position. It then checks that `led_o` is unchanged and that the next well-formed packet still takes effect. The alignment search is stressed in the same way: a filler byte is placed inside a run of markers, so that a run one short of the threshold must not bring the link up.

// File: rtl/cmd_node_pkg.sv
package cmd_node_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   localparam byte_t AM_CODE   = 8'h55;
   localparam byte_t SOP_CODE  = 8'hFB;
   localparam byte_t EOP_CODE  = 8'hFD;
   localparam byte_t IDLE_CODE = 8'h07;

   typedef enum logic [2:0] {
      PS_HUNT,
      PS_ID,
      PS_LEN,
      PS_CMD,
      PS_EOP
   } pstate_e;
endpackage

// File: rtl/cmd_node_align.sv
module cmd_node_align
   import cmd_node_pkg::*;
#(
   parameter int ALIGN_RUN = 5
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  in_vld,
   input  byte_t in_byte,
   output logic  link_up
);
   localparam int CNT_W = (ALIGN_RUN > 1) ? $clog2(ALIGN_RUN) : 1;

   logic link_q;
   logic is_marker;

   assign is_marker = in_vld && (in_byte == AM_CODE);
   assign link_up   = link_q;

   generate
      if (ALIGN_RUN == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) link_q <= 1'b0;
            else if (is_marker) link_q <= 1'b1;
         end
      end else begin : g_count
         logic [CNT_W-1:0] run_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q  <= '0;
               link_q <= 1'b0;
            end else if (!link_q && in_vld) begin
               if (is_marker) begin
                  if (run_q == CNT_W'(ALIGN_RUN - 1)) begin
                     link_q <= 1'b1;
                     run_q  <= '0;
                  end else begin
                     run_q <= run_q + 1'b1;
                  end
               end else begin
                  run_q <= '0;
               end
            end
         end

         AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            run_q < CNT_W'(ALIGN_RUN)); // R1
      end
   endgenerate

   AST_LINK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      link_q |=> link_q); // R1
   AST_NO_LINK_WITHOUT_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_q && !is_marker) |=> !link_q); // R2
endmodule

// File: rtl/cmd_node_repeat.sv
module cmd_node_repeat
   import cmd_node_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  link_up,
   input  logic  in_vld,
   input  byte_t in_byte,
   output logic  out_vld,
   output byte_t out_byte
);
   logic  vld_q;
   byte_t data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         data_q <= '0;
      end else begin
         vld_q <= link_up && in_vld;
         if (link_up && in_vld) data_q <= in_byte;
      end
   end

   assign out_vld  = vld_q;
   assign out_byte = data_q;

   AST_SILENT_BEFORE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |=> !out_vld); // R3
   AST_ONE_CYCLE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && in_vld) |=> (out_vld && out_byte == $past(in_byte))); // R4
endmodule

// File: rtl/cmd_node_parser.sv
module cmd_node_parser
   import cmd_node_pkg::*;
#(
   parameter byte_t NODE_ID = 8'h3C,
   parameter int    LED_CNT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  byte_t              rx_byte,
   output logic [LED_CNT-1:0] led,
   output logic               err
);
   pstate_e            state_q;
   logic               match_q;
   byte_t              left_q;
   logic [LED_CNT-1:0] stage_q;
   logic [LED_CNT-1:0] stage_nxt;
   logic [LED_CNT-1:0] led_q;
   logic               err_q;
   logic               is_sop;
   logic               eop_commit;

   assign is_sop = (rx_byte == SOP_CODE);

   // Per-LED command decode: upper nibble selects the LED, low nibble 0 = on, 1 = off.
   generate
      for (genvar i = 0; i < LED_CNT; i++) begin : g_led_dec
         logic hit_on, hit_off;
         assign hit_on  = (rx_byte == {4'(i), 4'h0});
         assign hit_off = (rx_byte == {4'(i), 4'h1});
         always_comb begin
            if (hit_on)       stage_nxt[i] = 1'b1;
            else if (hit_off) stage_nxt[i] = 1'b0;
            else              stage_nxt[i] = stage_q[i];
         end
      end
   endgenerate

   assign eop_commit = take && (state_q == PS_EOP) && (rx_byte == EOP_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PS_HUNT;
         match_q <= 1'b0;
         left_q  <= '0;
         stage_q <= '0;
         led_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (take) begin
            case (state_q)
               PS_HUNT: begin
                  if (is_sop) begin
                     state_q <= PS_ID;
                     stage_q <= led_q;
                  end
               end
               PS_ID: begin
                  if (is_sop) begin
                     err_q   <= 1'b1;
                     state_q <= PS_HUNT;
                  end else begin
                     match_q <= (rx_byte == NODE_ID);
                     state_q <= PS_LEN;
                  end
               end
               PS_LEN: begin
                  if (is_sop || rx_byte == '0) begin
                     err_q   <= 1'b1;
                     state_q <= PS_HUNT;
                  end else begin
                     left_q  <= rx_byte;
                     state_q <= PS_CMD;
                  end
               end
               PS_CMD: begin
                  if (is_sop) begin
                     err_q   <= 1'b1;
                     state_q <= PS_HUNT;
                  end else begin
                     if (match_q) stage_q <= stage_nxt;
                     if (left_q == 8'd1) state_q <= PS_EOP;
                     left_q <= left_q - 1'b1;
                  end
               end
               PS_EOP: begin
                  if (rx_byte == EOP_CODE) begin
                     if (match_q) led_q <= stage_q;
                  end else begin
                     err_q <= 1'b1;
                  end
                  state_q <= PS_HUNT;
               end
               default: state_q <= PS_HUNT;
            endcase
         end
      end
   end

   assign led = led_q;
   assign err = err_q;

   AST_LED_ONLY_AT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      !eop_commit |=> $stable(led_q)); // R5
   AST_LEN_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (take && state_q == PS_LEN && rx_byte == '0) |=> err_q); // R8
   AST_CMD_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_CMD) |-> (left_q != '0)); // R9
   AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> !err_q); // R10
   AST_MID_SOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (take && is_sop && state_q != PS_HUNT) |=> (err_q && state_q == PS_HUNT)); // R11
endmodule

// File: rtl/cmd_node.sv
module cmd_node
   import cmd_node_pkg::*;
#(
   parameter logic [7:0] NODE_ID   = 8'h3C,
   parameter int         ALIGN_RUN = 5,
   parameter int         LED_CNT   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_vld,
   input  logic [7:0]         in_byte,
   output logic               out_vld,
   output logic [7:0]         out_byte,
   output logic               link_up,
   output logic [LED_CNT-1:0] led_o,
   output logic               err_pulse
);
   logic link_w;
   logic take_w;

   initial begin
      AST_CFG_RUN: assert (ALIGN_RUN >= 1) else $error("ALIGN_RUN must be at least 1");
      AST_CFG_LEDS: assert (LED_CNT >= 1 && LED_CNT <= 16) else $error("LED_CNT must be 1..16");
      AST_CFG_ID: assert (NODE_ID != SOP_CODE) else $error("NODE_ID collides with start byte");
   end

   cmd_node_align #(.ALIGN_RUN(ALIGN_RUN)) u_align (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (in_vld),
      .in_byte (in_byte),
      .link_up (link_w)
   );

   assign take_w = link_w && in_vld;

   cmd_node_repeat u_repeat (
      .clk      (clk),
      .rst_n    (rst_n),
      .link_up  (link_w),
      .in_vld   (in_vld),
      .in_byte  (in_byte),
      .out_vld  (out_vld),
      .out_byte (out_byte)
   );

   cmd_node_parser #(.NODE_ID(NODE_ID), .LED_CNT(LED_CNT)) u_parser (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take_w),
      .rx_byte (in_byte),
      .led     (led_o),
      .err     (err_pulse)
   );

   assign link_up = link_w;

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!link_up && !out_vld && !err_pulse && led_o == '0)); // R12
endmodule

// File: tb/cmd_node_test.sv
`timescale 1ns/100ps
module cmd_node_test;
   localparam logic [7:0] NID = 8'h3C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_vld = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_vld;
   logic [7:0] out_byte;
   logic       link_up;
   logic [1:0] led_o;
   logic       err_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];
   bit  bench_link = 0;
   int  am_run = 0;

   always #2.5 clk = ~clk;

   cmd_node #(.NODE_ID(NID)) uut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
      .out_vld(out_vld), .out_byte(out_byte), .link_up(link_up),
      .led_o(led_o), .err_pulse(err_pulse)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // Driver: pushes the expected repeated byte into the scoreboard queue.
   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_vld  = 1'b1;
      in_byte = b;
      if (bench_link) exp_q.push_back(b);
      else if (b == 8'h55) begin
         am_run++;
         if (am_run == 5) bench_link = 1;
      end else am_run = 0;
   endtask

   task automatic gap();
      @(negedge clk);
      in_vld  = 1'b0;
      in_byte = 8'h00;
   endtask

   task automatic frame(input logic [7:0] id, input logic [7:0] cmd);
      send(8'h07); send(8'hFB); send(id); send(8'h01); send(cmd); send(8'hFD);
      gap();
   endtask

   // Monitor: pops and compares every repeated byte.
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         if (exp_q.size() == 0) chk(1'b0, "R3 output while link down", out_byte, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(out_byte == e, "R4 repeated byte", out_byte, e);
         end
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(link_up == 0 && out_vld == 0 && err_pulse == 0 && led_o == 2'b00,
          "R12 reset state", {link_up, out_vld, err_pulse, led_o}, 0);
      @(negedge clk); rst_n = 1'b1;

      // R2: broken run, then a run one short
      send(8'h55); send(8'h55); send(8'h55); send(8'h07);
      send(8'h55); send(8'h55); gap(); send(8'h55); send(8'h55); gap();
      chk(link_up == 0, "R2 link after 4 markers", link_up, 0);
      send(8'h55); gap();
      chk(link_up == 1, "R1 link after 5th marker", link_up, 1);
      chk(out_vld == 0, "R3 completing marker not repeated", out_vld, 0);

      // R5: commands commit only at end byte
      send(8'h07); send(8'hFB); send(NID); send(8'h01); send(8'h00); gap();
      chk(led_o == 2'b00, "R5 no change before end byte", led_o, 0);
      send(8'hFD); gap();
      chk(led_o == 2'b01, "R5 LED0 on after end byte", led_o, 1);
      chk(err_pulse == 0, "R5 no error on good packet", err_pulse, 0);

      frame(8'h3D, 8'h10);
      chk(led_o == 2'b01, "R6 foreign ID ignored", led_o, 1);
      chk(err_pulse == 0, "R6 no error on foreign packet", err_pulse, 0);

      frame(NID, 8'h10);
      chk(led_o == 2'b11, "R7 LED1 on", led_o, 3);
      frame(NID, 8'h22);
      chk(led_o == 2'b11, "R7 unknown command", led_o, 3);
      frame(NID, 8'h01);
      chk(led_o == 2'b10, "R7 LED0 off", led_o, 2);

      // R8: zero length
      send(8'h07); send(8'hFB); send(NID); send(8'h00); gap();
      chk(err_pulse == 1, "R8 error on zero length", err_pulse, 1);
      gap();
      chk(err_pulse == 0, "R8 error lasts one cycle", err_pulse, 0);
      chk(led_o == 2'b10, "R8 LEDs unchanged", led_o, 2);

      // R9: three commands in order
      send(8'hFB); send(NID); send(8'h03); send(8'h11); send(8'h00); send(8'h01);
      send(8'hFD); gap();
      chk(led_o == 2'b00, "R9 ordered commands", led_o, 0);

      // R10: wrong closing byte
      send(8'hFB); send(NID); send(8'h01); send(8'h00); send(8'h07); gap();
      chk(err_pulse == 1, "R10 error on missing end", err_pulse, 1);
      chk(led_o == 2'b00, "R10 commands discarded", led_o, 0);

      // R11: start byte mid-packet
      send(8'hFB); send(NID); send(8'h02); send(8'h10); send(8'hFB); gap();
      chk(err_pulse == 1, "R11 error on mid start", err_pulse, 1);
      chk(led_o == 2'b00, "R11 packet discarded", led_o, 0);
      frame(NID, 8'h10);
      chk(led_o == 2'b10, "R11 next packet parsed", led_o, 2);

      send(8'h07); send(8'h33); gap();
      chk(link_up == 1, "R1 link stays high", link_up, 1);
      gap(); gap();
      chk(exp_q.size() == 0, "R4 all bytes repeated", exp_q.size(), 0);
      finish_run();
   end
endmodule